// File: doc/BRIEF.md
# Transaction Latency Histogram Unit

This block measures how long each tagged transaction takes from issue to completion, counted in cycles of the monitor clock, and records the result as a histogram. A free-running timestamp counter is captured into a small table indexed by the transaction tag when a request is accepted. When a completion carrying the same tag arrives, the captured value is subtracted from the current count. The difference selects one of five bins, and that bin's counter is incremented.

The bin limits are held in registers. After reset they form an exponential layout, and software may rewrite them to any other layout, including a linear one. Software reads the bin counters through the same register port. It can set a freeze bit so that all counters hold still while a consistent set of values is read out. Software then takes the difference between two readouts to obtain the latency distribution for that window.

Requests arrive on a valid/ready stream. A request is held off with `req_ready` low while its tag is still outstanding, and the source must keep `req_valid` and `req_tag` steady until the request is accepted. Completions are never stalled: `cpl_ready` is tied high, and a completion is taken on every cycle in which `cpl_valid` is high.

Top module: `lat_hist`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Acceptance marks the tag outstanding and records the timestamp. `req_ready` is low exactly when the tag on `req_tag` is already outstanding.
- R2: The latency of a completion is the number of rising edges from the accepting edge to the completing edge, reduced modulo 2^TS_W. A result that is correct across a wrap of the timestamp counter therefore needs the true latency to stay below 2^TS_W.
- R3: Bins 0 to 3 are tested in index order. A bin matches when lower(k) <= latency <= upper(k), and the first matching bin is the one counted. Bin 4 has only a lower limit and takes every latency that no earlier bin takes.
- R4: After reset, the lower limits are 0, 16, 32, 64 and 128, and the upper limits of bins 0 to 3 are 15, 31, 63 and 127.
- R5: A register write replaces a bin limit, and the new limit applies to every later completion. A linear layout such as 0-9, 10-19, 20-29, 30-39 and 40 or more is therefore possible.
- R6: Every matched completion that arrives while the block is not frozen raises exactly one bin counter by one. Hardware never lowers a counter.
- R7: While the freeze bit is set, no bin counter changes. A completion that arrives while frozen still retires its tag, and it is not counted at any later time.
- R8: A completion whose tag is not outstanding changes no counter and no tag state. It sets a sticky error bit, which only reset clears.
- R9: A request on one tag and a completion on a different tag in the same cycle are both handled.
- R10: The register map is as follows. Address 0 holds the control word: bit 0 is the freeze bit (read/write) and bit 1 is the error bit (read-only). Addresses 1 to 5 hold the lower limits of bins 0 to 4. Addresses 6 to 9 hold the upper limits of bins 0 to 3. Addresses 10 to 14 hold the read-only counters of bins 0 to 4. `reg_rdata` follows `reg_addr` combinationally, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The presented tag is free and the request can be taken |
| req_tag | input | TAG_W | Tag of the request |
| cpl_valid | input | 1 | A completion is presented |
| cpl_ready | output | 1 | Always high; completions are never stalled |
| cpl_tag | input | TAG_W | Tag of the completion |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |

## Verification
The assertions assume that the request source keeps the stream rules. In particular, the tag stays stable until acceptance, so every completion that hits its tag refers to a request recorded at an earlier edge. The monotonic-counter check also assumes that no counter wraps within a test. The stimulus keeps to these assumptions. It presents requests one at a time, except in the deliberate overlap of one request with a completion on another tag. It never keeps a transaction open for 2^TS_W cycles or longer, and it sends only a few hundred completions, far below counter saturation. One long run of transactions is made to span a wrap of the timestamp counter, which the bench shortens to 10 bits for this purpose.

// File: rtl/lh_pkg.sv
package lh_pkg;
  localparam int ADDR_W    = 4;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_LO0  = 1;
  localparam int ADDR_HI0  = 6;
  localparam int ADDR_CNT0 = 10;

  // Exponential reset layout: bin k starts at 8<<k (bin 0 at zero)
  function automatic logic [31:0] dflt_lo(input int k);
    return (k == 0) ? 32'd0 : (32'd8 << k);
  endfunction

  function automatic logic [31:0] dflt_hi(input int k);
    return (32'd16 << k) - 32'd1;
  endfunction
endpackage

// File: rtl/lh_tag_table.sv
module lh_tag_table #(
  parameter int TAGS = 16,
  parameter int TS_W = 16,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  ts,
  input  logic             req_fire,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cpl_hit,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic [TAGS-1:0]  pend,
  output logic [TS_W-1:0]  cpl_start
);
  logic [TS_W-1:0] start_q [TAGS];

  for (genvar g = 0; g < TAGS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g]    <= 1'b0;
        start_q[g] <= '0;
      end else if (req_fire && req_tag == TAG_W'(g)) begin
        pend[g]    <= 1'b1;
        start_q[g] <= ts;
      end else if (cpl_hit && cpl_tag == TAG_W'(g)) begin
        pend[g]    <= 1'b0;
      end
    end
  end

  assign cpl_start = start_q[cpl_tag];

  AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> pend[$past(req_tag)]);  // R1
  AST_TAG_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && !(req_fire && req_tag == cpl_tag)) |=> !pend[$past(cpl_tag)]);  // R7
endmodule

// File: rtl/lh_bin_select.sv
module lh_bin_select #(
  parameter int BINS = 5,
  parameter int LAT_W = 16
) (
  input  logic [LAT_W-1:0]        lat,
  input  logic [BINS*LAT_W-1:0]   lo_flat,
  input  logic [(BINS-1)*LAT_W-1:0] hi_flat,
  output logic [BINS-1:0]         hit
);
  always_comb begin
    logic found;
    found = 1'b0;
    hit   = '0;
    for (int k = 0; k < BINS - 1; k++) begin
      if (!found && lat >= lo_flat[k*LAT_W +: LAT_W] &&
          lat <= hi_flat[k*LAT_W +: LAT_W]) begin
        hit[k] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) hit[BINS-1] = 1'b1;  // open-ended last bin catches the rest
  end
endmodule

// File: rtl/lh_bin_counters.sv
module lh_bin_counters #(
  parameter int BINS = 5,
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  logic                  freeze,
  input  logic [BINS-1:0]       hit,
  output logic [BINS*CNT_W-1:0] cnt_flat
);
  for (genvar g = 0; g < BINS; g++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_flat[g*CNT_W +: CNT_W] <= '0;
      else if (count_en && !freeze && hit[g])
        cnt_flat[g*CNT_W +: CNT_W] <= cnt_flat[g*CNT_W +: CNT_W] + 1'b1;
    end

    AST_NO_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W]));  // R6
  end

  AST_ONE_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> $onehot(hit));  // R3
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cnt_flat));  // R7
endmodule

// File: rtl/lat_hist.sv
module lat_hist #(
  parameter int TAGS   = 16,
  parameter int BINS   = 5,
  parameter int TS_W   = 16,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [TAG_W-1:0]          req_tag,
  input  logic                      cpl_valid,
  output logic                      cpl_ready,
  input  logic [TAG_W-1:0]          cpl_tag,
  input  logic                      reg_wr_en,
  input  logic [lh_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata
);
  import lh_pkg::*;

  logic [TS_W-1:0]            ts_q;
  logic [TAGS-1:0]            pend;
  logic [TS_W-1:0]            cpl_start;
  logic [TS_W-1:0]            lat;
  logic                       req_fire, cpl_hit;
  logic                       freeze_q, err_q;
  logic [BINS*TS_W-1:0]       lo_q;
  logic [(BINS-1)*TS_W-1:0]   hi_q;
  logic [BINS-1:0]            hit;
  logic [BINS*CNT_W-1:0]      cnt_flat;

  assign req_ready = !pend[req_tag];
  assign cpl_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign cpl_hit   = cpl_valid && pend[cpl_tag];
  assign lat       = ts_q - cpl_start;  // modular difference survives wrap

  always_ff @(posedge clk) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (reg_wr_en && int'(reg_addr) == ADDR_CTRL) freeze_q <= reg_wdata[0];
      if (cpl_valid && !cpl_hit) err_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < BINS; g++) begin : g_lo
    always_ff @(posedge clk) begin
      if (!rst_n) lo_q[g*TS_W +: TS_W] <= TS_W'(dflt_lo(g));
      else if (reg_wr_en && int'(reg_addr) == ADDR_LO0 + g)
        lo_q[g*TS_W +: TS_W] <= reg_wdata[TS_W-1:0];
    end
  end

  for (genvar g = 0; g < BINS - 1; g++) begin : g_hi
    always_ff @(posedge clk) begin
      if (!rst_n) hi_q[g*TS_W +: TS_W] <= TS_W'(dflt_hi(g));
      else if (reg_wr_en && int'(reg_addr) == ADDR_HI0 + g)
        hi_q[g*TS_W +: TS_W] <= reg_wdata[TS_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == ADDR_CTRL) reg_rdata[1:0] = {err_q, freeze_q};
    for (int k = 0; k < BINS; k++) begin
      if (int'(reg_addr) == ADDR_LO0 + k)
        reg_rdata = DATA_W'(lo_q[k*TS_W +: TS_W]);
      if (int'(reg_addr) == ADDR_CNT0 + k)
        reg_rdata = DATA_W'(cnt_flat[k*CNT_W +: CNT_W]);
    end
    for (int k = 0; k < BINS - 1; k++) begin
      if (int'(reg_addr) == ADDR_HI0 + k)
        reg_rdata = DATA_W'(hi_q[k*TS_W +: TS_W]);
    end
  end

  lh_tag_table #(.TAGS(TAGS), .TS_W(TS_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .ts(ts_q),
    .req_fire(req_fire), .req_tag(req_tag),
    .cpl_hit(cpl_hit), .cpl_tag(cpl_tag),
    .pend(pend), .cpl_start(cpl_start)
  );

  lh_bin_select #(.BINS(BINS), .LAT_W(TS_W)) u_sel (
    .lat(lat), .lo_flat(lo_q), .hi_flat(hi_q), .hit(hit)
  );

  lh_bin_counters #(.BINS(BINS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(cpl_hit), .freeze(freeze_q),
    .hit(hit), .cnt_flat(cnt_flat)
  );

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);  // R8
  AST_UNMATCHED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !pend[cpl_tag]) |=> err_q);  // R8
  AST_CPL_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready);  // R8
endmodule

// File: tb/lat_hist_bench.sv
`timescale 1ns/100ps
module lat_hist_bench;
  localparam int TAG_W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cpl_valid = 1'b0, reg_wr_en = 1'b0;
  logic [TAG_W-1:0] req_tag = '0, cpl_tag = '0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic req_ready, cpl_ready;
  logic [31:0] reg_rdata;

  int total = 0, bad = 0;
  int exp_cnt [5] = '{0, 0, 0, 0, 0};

  // R1..R6 vectors: latency in cycles and the bin it must land in
  localparam int NV = 10;
  localparam int VLAT [NV] = '{1, 15, 16, 31, 32, 63, 64, 127, 128, 300};
  localparam int VBIN [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 4, 4};

  always #2.5 clk = ~clk;

  lat_hist #(.TS_W(10)) u_lat_hist (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int addr, output int val);
    reg_addr = addr[3:0];
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic wr(input int addr, input int val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = addr[3:0]; reg_wdata = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic issue(input int tag);
    @(negedge clk);
    req_valid = 1'b1; req_tag = tag[3:0];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // called right after issue(): completion sampled lat edges after acceptance
  task automatic finish_after(input int tag, input int lat);
    repeat (lat - 1) @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = tag[3:0];
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic check_bins(input string req);
    int v;
    for (int k = 0; k < 5; k++) begin
      rd(10 + k, v);
      chk(req, v, exp_cnt[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R4 defaults, R10 map, R6 zero counters
    rd(0, v); chk("R10 ctrl reset", v, 0);
    for (int k = 0; k < 5; k++) begin
      rd(1 + k, v); chk("R4 lower limit", v, (k == 0) ? 0 : (8 << k));
    end
    for (int k = 0; k < 4; k++) begin
      rd(6 + k, v); chk("R4 upper limit", v, (16 << k) - 1);
    end
    rd(15, v); chk("R10 unmapped reads zero", v, 0);
    check_bins("R6 reset counters");
    req_tag = 4'd2; #1;
    chk("R1 ready when tag free", int'(req_ready), 1);

    // Vector table: R2 latency, R3 bin choice at every boundary
    for (int i = 0; i < NV; i++) begin
      issue(i % 16);
      req_tag = 4'(i % 16); #1;
      chk("R1 ready low while outstanding", int'(req_ready), 0);
      finish_after(i % 16, VLAT[i]);
      exp_cnt[VBIN[i]]++;
      check_bins("R3 bin selection");
    end

    // R2 wrap: 8 transactions of 150 cycles span a 10-bit timestamp wrap
    for (int i = 0; i < 8; i++) begin
      issue(5);
      finish_after(5, 150);
      exp_cnt[4]++;
      rd(14, v); chk("R2 latency across wrap", v, exp_cnt[4]);
      rd(13, v); chk("R2 no stray bin", v, exp_cnt[3]);
    end

    // R8: completion on a tag that is not outstanding
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = 4'd9;
    @(negedge clk);
    cpl_valid = 1'b0;
    rd(0, v); chk("R8 error bit set", v, 2);
    check_bins("R8 unmatched not counted");
    req_tag = 4'd9; #1;
    chk("R8 tag state untouched", int'(req_ready), 1);

    // R7: freeze holds counters, completion still retires tag
    wr(0, 1);
    issue(7);
    finish_after(7, 5);
    check_bins("R7 frozen counters hold");
    req_tag = 4'd7; #1;
    chk("R7 tag retired while frozen", int'(req_ready), 1);
    wr(0, 0);
    rd(0, v); chk("R8 error stays sticky", v, 2);
    check_bins("R7 no late count");

    // R9: request on tag 4 and completion on tag 3 in one cycle
    issue(3);
    repeat (19) @(negedge clk);
    req_valid = 1'b1; req_tag = 4'd4;
    cpl_valid = 1'b1; cpl_tag = 4'd3;
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    exp_cnt[1]++;  // latency 20
    check_bins("R9 completion counted");
    req_tag = 4'd4; #1;
    chk("R9 request accepted", int'(req_ready), 0);
    req_tag = 4'd3; #1;
    chk("R9 completed tag free", int'(req_ready), 1);
    cpl_valid = 1'b0;
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = 4'd4;
    @(negedge clk);
    cpl_valid = 1'b0;
    exp_cnt[0]++;  // latency 2
    check_bins("R9 second tag counted");

    // R5: linear layout
    for (int k = 1; k < 5; k++) wr(k + 1, 10 * k);
    for (int k = 0; k < 4; k++) wr(6 + k, 10 * k + 9);
    rd(3, v); chk("R5 limit readback", v, 20);
    issue(1); finish_after(1, 25); exp_cnt[2]++;
    check_bins("R5 linear middle bin");
    issue(1); finish_after(1, 9);  exp_cnt[0]++;
    check_bins("R5 linear first bin edge");
    issue(1); finish_after(1, 40); exp_cnt[4]++;
    check_bins("R5 linear open bin");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule